// File: doc/BRIEF.md
# Multicycle Controller with Exception Trap

This block is the control unit of a multicycle 32-bit RISC datapath. It steps each instruction through fetch, decode, execute, memory and writeback. It supports five instruction classes: word load, word store, register-register ALU operations, branch-if-equal and unconditional jump. Each step drives the datapath strobes and mux selects for that cycle. Alongside the state machine sit the program counter and the two trap registers: the saved-PC register and the cause register. The control sequence and the register updates are therefore observable together at one boundary.

Two conditions trap:
- **Unknown opcode.** An opcode that matches no supported class is caught in the decode step.
- **Arithmetic overflow.** The ALU overflow flag is sampled while a register-register operation completes its ALU step. The register-file write for that instruction never happens.

A trap takes one cycle and returns to fetch. In that cycle the controller:
- stores the address of the offending instruction (the already advanced PC minus 4) as the saved PC;
- writes the source into bit 0 of the cause register;
- loads the PC with the fixed handler entry 0xC000_0000.

Top module: `mcx_ctrl_top`

## Requirements
- R1: A synchronous active-high reset sets the PC, saved PC and cause register to 0 and puts the controller in fetch.
- R2: Every instruction starts with a fetch cycle that asserts memory read, instruction-register write and PC write, with address select 0, ALU B select 1 (constant 4) and PC source 0 (ALU result); the PC then holds the ALU result.
- R3: Opcodes are decoded as register-register 0x00, jump 0x02, branch-equal 0x04, load 0x23 and store 0x2B. These take, from fetch to the next fetch, 4, 3, 3, 5 and 4 cycles respectively.
- R4: Any other opcode leads from decode to one trap cycle. That cycle asserts saved-PC write, cause write and PC write with PC source 3, and cause-select 0.
- R5: A register-register instruction whose ALU step sees overflow high goes to a trap cycle with cause-select 1 and never asserts register write. Its total length stays 4 cycles.
- R6: A trap loads the saved PC with the current PC minus 4. It loads the cause register with 0 for an unknown opcode and 1 for overflow, in bit 0, with all upper bits 0.
- R7: A trap loads the PC with 0xC000_0000.
- R8: Outside trap cycles, the saved PC and the cause register keep their values.
- R9: Branch-equal asserts the conditional PC write with PC source 1 (ALU output register). The PC takes that register only when the zero flag is high; otherwise it keeps the fetched value.
- R10: Jump loads the PC with the jump-target input through PC source 2.
- R11: Overflow has no effect in any step other than the register-register ALU step. Load, store, branch and jump complete normally with overflow held high.
- R12: Register write occurs only for load (memory-to-register 1, destination select 0) and register-register (memory-to-register 0, destination select 1). Data-memory read (address select 1) occurs only for load. Memory write (address select 1) occurs only for store, exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_overflow | input | 1 | ALU signed overflow flag |
| alu_zero | input | 1 | ALU zero flag |
| alu_result | input | 32 | Combinational ALU result |
| alu_out_q | input | 32 | ALU output register |
| jump_target | input | 32 | Assembled jump address |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write qualified by zero |
| i_or_d | output | 1 | Memory address select: 0 PC, 1 ALU output |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Write-back source: 1 memory data |
| reg_dst | output | 1 | Destination select: 1 rd, 0 rt |
| reg_write | output | 1 | Register file write |
| alu_src_a | output | 1 | ALU A select: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B select: 0 reg B, 1 constant 4, 2 immediate, 3 shifted immediate |
| alu_op | output | 2 | ALU operation class: 0 add, 1 subtract, 2 function field |
| pc_source | output | 2 | PC source: 0 ALU result, 1 ALU output reg, 2 jump target, 3 handler |
| epc_write | output | 1 | Saved-PC register load |
| cause_write | output | 1 | Cause register load |
| int_cause | output | 1 | Cause bit 0 value: 0 unknown opcode, 1 overflow |
| pc_q | output | 32 | Program counter |
| epc_q | output | 32 | Saved PC of the last trapping instruction |
| cause_q | output | 32 | Cause register |

## Verification
The assertions assume that the opcode input is stable from decode until the instruction returns to fetch. They also assume that the overflow and zero flags are meaningful only in the steps that consume them, and never take an unknown value. The stimulus holds each instruction's opcode, flags and address inputs constant from its fetch cycle to the next fetch. It sweeps all 64 opcodes against all four combinations of overflow and zero, so that the flags are deliberately high in steps that must ignore them. The ALU result, ALU output register and jump target get distinct values per instruction. This makes every PC source select distinguishable at the PC.

// File: rtl/mcx_pkg.sv
package mcx_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_MADDR, ST_MREAD, ST_MLOAD, ST_MSTORE,
        ST_REXEC, ST_RWB, ST_BEQ, ST_JUMP, ST_XUNDEF, ST_XOVF
    } state_e;

    typedef enum logic [1:0] {
        PCS_ALU = 2'd0, PCS_ALUOUT = 2'd1, PCS_JUMP = 2'd2, PCS_TRAP = 2'd3
    } pcsrc_e;

    typedef struct packed {
        logic       pc_write;
        logic       pc_write_cond;
        logic       i_or_d;
        logic       mem_read;
        logic       mem_write;
        logic       ir_write;
        logic       mem_to_reg;
        logic       reg_dst;
        logic       reg_write;
        logic       alu_src_a;
        logic [1:0] alu_src_b;
        logic [1:0] alu_op;
        pcsrc_e     pc_source;
        logic       epc_write;
        logic       cause_write;
        logic       int_cause;
    } ctrl_t;

    function automatic logic op_known(input logic [5:0] op);
        return (op == OPC_RTYPE) || (op == OPC_JUMP) || (op == OPC_BEQ) ||
               (op == OPC_LOAD)  || (op == OPC_STORE);
    endfunction

    function automatic ctrl_t ctrl_of(input state_e s);
        ctrl_t c;
        c = '0;
        c.pc_source = PCS_ALU;
        case (s)
            ST_FETCH: begin
                c.mem_read = 1'b1; c.ir_write = 1'b1; c.pc_write = 1'b1;
                c.alu_src_b = 2'd1;
            end
            ST_DECODE: c.alu_src_b = 2'd3;
            ST_MADDR: begin c.alu_src_a = 1'b1; c.alu_src_b = 2'd2; end
            ST_MREAD: begin c.mem_read = 1'b1; c.i_or_d = 1'b1; end
            ST_MLOAD: begin c.reg_write = 1'b1; c.mem_to_reg = 1'b1; end
            ST_MSTORE: begin c.mem_write = 1'b1; c.i_or_d = 1'b1; end
            ST_REXEC: begin c.alu_src_a = 1'b1; c.alu_op = 2'd2; end
            ST_RWB: begin c.reg_write = 1'b1; c.reg_dst = 1'b1; end
            ST_BEQ: begin
                c.alu_src_a = 1'b1; c.alu_op = 2'd1;
                c.pc_write_cond = 1'b1; c.pc_source = PCS_ALUOUT;
            end
            ST_JUMP: begin c.pc_write = 1'b1; c.pc_source = PCS_JUMP; end
            ST_XUNDEF, ST_XOVF: begin
                c.pc_write = 1'b1; c.pc_source = PCS_TRAP;
                c.epc_write = 1'b1; c.cause_write = 1'b1;
                c.int_cause = (s == ST_XOVF);
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mcx_sequencer.sv
module mcx_sequencer
    import mcx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic       alu_overflow,
    output ctrl_t      ctrl
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_LOAD, OPC_STORE: state_d = ST_MADDR;
                    OPC_RTYPE:           state_d = ST_REXEC;
                    OPC_BEQ:             state_d = ST_BEQ;
                    OPC_JUMP:            state_d = ST_JUMP;
                    default:             state_d = ST_XUNDEF;
                endcase
            end
            ST_MADDR:  state_d = (opcode == OPC_LOAD) ? ST_MREAD : ST_MSTORE;
            ST_MREAD:  state_d = ST_MLOAD;
            ST_REXEC:  state_d = alu_overflow ? ST_XOVF : ST_RWB;
            default:   state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    assign ctrl = ctrl_of(state_q);

    // R4
    undef_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && !op_known(opcode)) |=>
        (ctrl.epc_write && ctrl.cause_write && ctrl.pc_source == PCS_TRAP && !ctrl.int_cause));

    // R5
    ovf_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REXEC && alu_overflow) |=>
        (ctrl.cause_write && ctrl.int_cause && !ctrl.reg_write));

    // R12
    no_wr_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.mem_write && ctrl.reg_write));

endmodule

// File: rtl/mcx_sysregs.sv
module mcx_sysregs
    import mcx_pkg::*;
#(
    parameter int               XLEN         = 32,
    parameter logic [XLEN-1:0]  HANDLER_ADDR = 32'hC000_0000,
    parameter int               PC_STEP      = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  ctrl_t           ctrl,
    input  logic            alu_zero,
    input  logic [XLEN-1:0] alu_result,
    input  logic [XLEN-1:0] alu_out_q,
    input  logic [XLEN-1:0] jump_target,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    logic [XLEN-1:0] pc_next;
    logic            pc_en;

    always_comb begin
        case (ctrl.pc_source)
            PCS_ALU:    pc_next = alu_result;
            PCS_ALUOUT: pc_next = alu_out_q;
            PCS_JUMP:   pc_next = jump_target;
            default:    pc_next = HANDLER_ADDR;
        endcase
    end

    assign pc_en = ctrl.pc_write || (ctrl.pc_write_cond && alu_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            epc_q   <= '0;
            cause_q <= '0;
        end else begin
            if (pc_en)            pc_q    <= pc_next;
            if (ctrl.epc_write)   epc_q   <= pc_q - STEP;
            if (ctrl.cause_write) cause_q <= {{(XLEN-1){1'b0}}, ctrl.int_cause};
        end
    end

    // R8
    epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.epc_write |=> $stable(epc_q));

    // R8
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.cause_write |=> $stable(cause_q));

    // R6
    epc_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.epc_write |=> (epc_q == $past(pc_q) - STEP));

    // R7
    handler_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc_write && ctrl.pc_source == PCS_TRAP) |=> (pc_q == HANDLER_ADDR));

endmodule

// File: rtl/mcx_ctrl_top.sv
module mcx_ctrl_top
    import mcx_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'hC000_0000,
    parameter int              PC_STEP      = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [5:0]      opcode,
    input  logic            alu_overflow,
    input  logic            alu_zero,
    input  logic [XLEN-1:0] alu_result,
    input  logic [XLEN-1:0] alu_out_q,
    input  logic [XLEN-1:0] jump_target,
    output logic            pc_write,
    output logic            pc_write_cond,
    output logic            i_or_d,
    output logic            mem_read,
    output logic            mem_write,
    output logic            ir_write,
    output logic            mem_to_reg,
    output logic            reg_dst,
    output logic            reg_write,
    output logic            alu_src_a,
    output logic [1:0]      alu_src_b,
    output logic [1:0]      alu_op,
    output logic [1:0]      pc_source,
    output logic            epc_write,
    output logic            cause_write,
    output logic            int_cause,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q
);
    ctrl_t ctrl;

    mcx_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .opcode       (opcode),
        .alu_overflow (alu_overflow),
        .ctrl         (ctrl)
    );

    mcx_sysregs #(
        .XLEN         (XLEN),
        .HANDLER_ADDR (HANDLER_ADDR),
        .PC_STEP      (PC_STEP)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .alu_zero    (alu_zero),
        .alu_result  (alu_result),
        .alu_out_q   (alu_out_q),
        .jump_target (jump_target),
        .pc_q        (pc_q),
        .epc_q       (epc_q),
        .cause_q     (cause_q)
    );

    assign pc_write      = ctrl.pc_write;
    assign pc_write_cond = ctrl.pc_write_cond;
    assign i_or_d        = ctrl.i_or_d;
    assign mem_read      = ctrl.mem_read;
    assign mem_write     = ctrl.mem_write;
    assign ir_write      = ctrl.ir_write;
    assign mem_to_reg    = ctrl.mem_to_reg;
    assign reg_dst       = ctrl.reg_dst;
    assign reg_write     = ctrl.reg_write;
    assign alu_src_a     = ctrl.alu_src_a;
    assign alu_src_b     = ctrl.alu_src_b;
    assign alu_op        = ctrl.alu_op;
    assign pc_source     = ctrl.pc_source;
    assign epc_write     = ctrl.epc_write;
    assign cause_write   = ctrl.cause_write;
    assign int_cause     = ctrl.int_cause;

    // R2
    fetch_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ir_write |-> (mem_read && pc_write && !i_or_d && pc_source == 2'd0));

endmodule

// File: tb/test_mcx_ctrl_top.sv
module test_mcx_ctrl_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic        alu_overflow = 1'b0;
    logic        alu_zero = 1'b0;
    logic [31:0] alu_result = '0;
    logic [31:0] alu_out_q = '0;
    logic [31:0] jump_target = '0;
    logic        pc_write, pc_write_cond, i_or_d, mem_read, mem_write, ir_write;
    logic        mem_to_reg, reg_dst, reg_write, alu_src_a;
    logic [1:0]  alu_src_b, alu_op, pc_source;
    logic        epc_write, cause_write, int_cause;
    logic [31:0] pc_q, epc_q, cause_q;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mcx_ctrl_top i_mcx_ctrl_top (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_overflow(alu_overflow),
        .alu_zero(alu_zero), .alu_result(alu_result), .alu_out_q(alu_out_q),
        .jump_target(jump_target), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
        .i_or_d(i_or_d), .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
        .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .reg_write(reg_write),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .pc_source(pc_source), .epc_write(epc_write), .cause_write(cause_write),
        .int_cause(int_cause), .pc_q(pc_q), .epc_q(epc_q), .cause_q(cause_q)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] exp_epc = '0;
    logic [31:0] exp_cause = '0;

    task automatic run_instr(input logic [5:0] op, input bit ovf, input bit zf,
                             input int idx);
        int          cyc = 0;
        int          n_regw = 0, n_memw = 0, n_exc = 0;
        int          exp_cyc, exp_regw, exp_memw;
        bit          trap, known;
        logic [31:0] a, exp_pc;
        a = 32'h0000_1000 + 32'(idx) * 8;
        opcode       = op;
        alu_overflow = ovf;
        alu_zero     = zf;
        alu_result   = a;
        alu_out_q    = 32'h2000_0000 ^ 32'(idx);
        jump_target  = 32'h0040_0000 + 32'(idx) * 4;
        known = (op == 6'h00) || (op == 6'h02) || (op == 6'h04) ||
                (op == 6'h23) || (op == 6'h2B);
        trap = !known || (op == 6'h00 && ovf);
        case (op)
            6'h23:   begin exp_cyc = 5; exp_regw = 1; exp_memw = 0; end
            6'h2B:   begin exp_cyc = 4; exp_regw = 0; exp_memw = 1; end
            6'h00:   begin exp_cyc = 4; exp_regw = ovf ? 0 : 1; exp_memw = 0; end
            6'h04,
            6'h02:   begin exp_cyc = 3; exp_regw = 0; exp_memw = 0; end
            default: begin exp_cyc = 3; exp_regw = 0; exp_memw = 0; end
        endcase
        if (trap)            exp_pc = 32'hC000_0000;
        else if (op == 6'h02) exp_pc = jump_target;
        else if (op == 6'h04) exp_pc = zf ? alu_out_q : a;
        else                 exp_pc = a;
        do begin
            if (cyc == 0) begin
                // R2 fetch strobes and selects
                check(ir_write && mem_read && pc_write && !i_or_d && alu_src_b == 2'd1 &&
                      pc_source == 2'd0, "R2 fetch controls",
                      {26'd0, ir_write, mem_read, pc_write, i_or_d, alu_src_b},
                      32'b111001);
            end
            if (cyc == 1) check(pc_q == a, "R2 pc after fetch", pc_q, a);
            if (reg_write) begin
                n_regw++;
                // R12 write-back source and destination
                check(mem_to_reg == (op == 6'h23) && reg_dst == (op == 6'h00),
                      "R12 writeback selects", {30'd0, mem_to_reg, reg_dst},
                      {30'd0, op == 6'h23, op == 6'h00});
            end
            if (mem_write) begin
                n_memw++;
                check(i_or_d, "R12 store address select", 32'(i_or_d), 32'd1);
            end
            if (mem_read && cyc != 0)
                check(i_or_d && op == 6'h23, "R12 data read only for load",
                      {26'd0, op}, 32'h23);
            if (pc_write_cond)
                // R9 branch selects ALU output register
                check(op == 6'h04 && pc_source == 2'd1, "R9 branch pc source",
                      32'(pc_source), 32'd1);
            if (epc_write) begin
                n_exc++;
                // R4 / R5 trap cycle strobes
                check(cause_write && pc_write && pc_source == 2'd3 &&
                      int_cause == (known ? 1'b1 : 1'b0),
                      known ? "R5 overflow trap controls" : "R4 undefined trap controls",
                      {28'd0, cause_write, pc_write, int_cause, pc_source == 2'd3},
                      {28'd0, 1'b1, 1'b1, known, 1'b1});
            end
            cyc++;
            @(posedge clk);
            @(negedge clk);
        end while (!ir_write && cyc < 9);
        if (trap) begin
            exp_epc   = a - 32'd4;
            exp_cause = {31'd0, known};
        end
        check(cyc == exp_cyc, trap ? "R4 trap length" : "R3 instruction length",
              32'(cyc), 32'(exp_cyc));
        check(n_regw == exp_regw, ovf && op == 6'h00 ? "R5 write suppressed" : "R12 reg write count",
              32'(n_regw), 32'(exp_regw));
        check(n_memw == exp_memw, "R12 mem write count", 32'(n_memw), 32'(exp_memw));
        check(n_exc == (trap ? 1 : 0), ovf ? "R11 overflow ignored / trapped" : "R4 trap count",
              32'(n_exc), 32'(trap ? 1 : 0));
        check(pc_q == exp_pc,
              trap ? "R7 handler entry" : (op == 6'h02 ? "R10 jump" :
              (op == 6'h04 ? "R9 branch" : "R2 sequential pc")), pc_q, exp_pc);
        check(epc_q == exp_epc, trap ? "R6 saved pc" : "R8 saved pc held", epc_q, exp_epc);
        check(cause_q == exp_cause, trap ? "R6 cause value" : "R8 cause held",
              cause_q, exp_cause);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(pc_q == 32'd0, "R1 pc reset", pc_q, 32'd0);
        check(epc_q == 32'd0 && cause_q == 32'd0, "R1 trap regs reset", epc_q | cause_q, 32'd0);
        check(ir_write, "R1 starts in fetch", 32'(ir_write), 32'd1);
        for (int op = 0; op < 64; op++) begin
            for (int v = 0; v < 4; v++) begin
                run_instr(6'(op), v[0], v[1], op * 4 + v);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule